// File: doc/BRIEF.md
# Serial EEPROM Slave Address Decoder

This block handles the address phase of a two-wire serial EEPROM slave. It synchronises the clock and data lines into the system clock domain and watches them for start and stop conditions. After a start, it shifts in the first byte, most significant bit first. That byte is matched against a fixed four-bit device identifier and against the levels strapped on three address pins. When the byte matches, the block pulls the data line low for the ninth clock pulse as an acknowledge.

A parameter sets how many of the three device-address bits act as memory block-select bits. The value is 0 to 3, and the block-select bits are always the lowest positions, starting at bit 1. These bits are not compared with the pins. They are captured and output as the upper bits of the word address, and each value picks one 256-word block. A larger setting leaves fewer pin-compared bits, so fewer devices can share the bus. With all three bits used as block select, only one device can be on the bus.

The outputs are:
- a one-cycle match strobe;
- the captured read/write direction;
- the captured block-select bits.

These outputs feed the logic that handles the word address and data. That logic sits outside this block.

Top module: `eeprom_addr_decoder`

## Requirements
- R1: After reset, sda_oe_o, match_o, rw_o and blk_sel_o are all 0.
- R2: When the address byte matches, sda_oe_o becomes 1 shortly after the falling edge of the eighth SCL pulse following the start. It stays 1 through the whole ninth SCL pulse and returns to 0 shortly after the ninth falling edge.
- R3: If address byte bits 7..4 differ from 4'b1010, there is no acknowledge and no match_o pulse.
- R4: Byte bit i (i = 1..3) is compared with pin_addr_i[i-1] only when i > BLK_BITS. A difference on any compared bit gives no acknowledge and no match_o pulse.
- R5: Byte bits i = 1..BLK_BITS are block-select bits and are not compared. On a match they appear on blk_sel_o[i-1]. blk_sel_o bits at positions BLK_BITS and above are 0.
- R6: On a match, rw_o takes byte bit 0 (1 means read, 0 means write).
- R7: match_o is a single-cycle pulse, issued once for each matched address byte, in the cycle the acknowledge drive begins.
- R8: After a mismatch, or after the acknowledge, the block ignores the bus until the next start condition. A further byte without a new start gets no acknowledge.
- R9: A start condition (SDA falls while SCL is high) clears the bit count at any point and restarts address capture. A stop condition (SDA rises while SCL is high) abandons the transfer.
- R10: rw_o and blk_sel_o change only together with a match_o pulse. They keep their values across mismatches and stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level (asynchronous) |
| sda_i | input | 1 | Serial data line level (asynchronous) |
| pin_addr_i | input | 3 | Strapped address pins; bit 0 pairs with byte bit 1 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| match_o | output | 1 | One-cycle strobe on an address match |
| rw_o | output | 1 | Captured direction bit of the last match |
| blk_sel_o | output | 3 | Captured block-select bits of the last match |

## Verification
The hardest case to reach is a condition that arrives in the middle of a byte. A start or stop after only a few bits have been clocked in must discard the partial shift. Afterwards, the next byte must be judged either as a fresh address or as ignored traffic. The stimulus clocks three bits, then raises SDA while SCL is low and issues a new start, or issues a stop instead. It then sends a full valid address. The stimulus also sends a valid address right after a rejected byte with no start between them, to show that the block stays deaf to the bus. Finally, it clears the bit that is pin-compared while setting the block-select bit opposite to its pin, to show which fields take part in the comparison.

// File: rtl/eea_pkg.sv
package eea_pkg;

    localparam int         ADDR_BITS = 8;
    localparam int         DEV_BITS  = 3;
    localparam logic [3:0] DEV_ID    = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_IGNORE
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic                hit;
        logic                rw;
        logic [DEV_BITS-1:0] blk;
    } addr_dec_t;

    function automatic logic id_matches(input logic [ADDR_BITS-1:0] b);
        return b[ADDR_BITS-1 -: 4] == DEV_ID;
    endfunction

endpackage

// File: rtl/eea_line_sync.sv
module eea_line_sync
    import eea_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    // R9
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.start, ev_o.stop, ev_o.scl_rise, ev_o.scl_fall}));

endmodule

// File: rtl/eea_addr_cmp.sv
module eea_addr_cmp
    import eea_pkg::*;
#(
    parameter int BLK_BITS = 1
) (
    input  logic [ADDR_BITS-1:0] addr_byte_i,
    input  logic [DEV_BITS-1:0]  pins_i,
    output addr_dec_t            dec_o
);

    logic [DEV_BITS-1:0] pin_ok;
    logic [DEV_BITS-1:0] blk;

    generate
        for (genvar i = 0; i < DEV_BITS; i++) begin : g_bit
            if (i < BLK_BITS) begin : g_blk
                assign pin_ok[i] = 1'b1;
                assign blk[i]    = addr_byte_i[i+1];
            end else begin : g_pin
                assign pin_ok[i] = addr_byte_i[i+1] == pins_i[i];
                assign blk[i]    = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        dec_o.hit = id_matches(addr_byte_i) & (&pin_ok);
        dec_o.rw  = addr_byte_i[0];
        dec_o.blk = blk;
    end

endmodule

// File: rtl/eea_addr_fsm.sv
module eea_addr_fsm
    import eea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  line_ev_t             ev_i,
    input  addr_dec_t            dec_i,
    output logic [ADDR_BITS-1:0] shreg_o,
    output logic                 sda_oe_o,
    output logic                 match_o,
    output logic                 rw_o,
    output logic [DEV_BITS-1:0]  blk_sel_o
);

    localparam int CNT_W = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BITS);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            cnt       <= '0;
            shreg_o   <= '0;
            sda_oe_o  <= 1'b0;
            match_o   <= 1'b0;
            rw_o      <= 1'b0;
            blk_sel_o <= '0;
        end else begin
            match_o <= 1'b0;
            if (ev_i.start) begin
                phase    <= ST_SHIFT;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                phase    <= ST_IDLE;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                case (phase)
                    ST_SHIFT: begin
                        if (ev_i.scl_rise && cnt != FULL) begin
                            shreg_o <= {shreg_o[ADDR_BITS-2:0], ev_i.sda};
                            cnt     <= cnt + 1'b1;
                        end else if (ev_i.scl_fall && cnt == FULL) begin
                            if (dec_i.hit) begin
                                phase     <= ST_ACK;
                                sda_oe_o  <= 1'b1;
                                match_o   <= 1'b1;
                                rw_o      <= dec_i.rw;
                                blk_sel_o <= dec_i.blk;
                            end else begin
                                phase <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev_i.scl_fall) begin
                            sda_oe_o <= 1'b0;
                            phase    <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> $past(ev_i.scl_fall));

    // R2
    oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> $past(ev_i.scl_fall || ev_i.start || ev_i.stop));

    // R7
    match_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);

    // R3
    match_id_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |-> id_matches(shreg_o));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !match_o |-> ($stable(rw_o) && $stable(blk_sel_o)));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> !sda_oe_o);

endmodule

// File: rtl/eeprom_addr_decoder.sv
module eeprom_addr_decoder
    import eea_pkg::*;
#(
    parameter int BLK_BITS    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [DEV_BITS-1:0] pin_addr_i,
    output logic                sda_oe_o,
    output logic                match_o,
    output logic                rw_o,
    output logic [DEV_BITS-1:0] blk_sel_o
);

    line_ev_t              ev;
    addr_dec_t             dec;
    logic [ADDR_BITS-1:0]  shreg;

    eea_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eea_addr_cmp #(.BLK_BITS(BLK_BITS)) u_cmp (
        .addr_byte_i (shreg),
        .pins_i      (pin_addr_i),
        .dec_o       (dec)
    );

    eea_addr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .dec_i     (dec),
        .shreg_o   (shreg),
        .sda_oe_o  (sda_oe_o),
        .match_o   (match_o),
        .rw_o      (rw_o),
        .blk_sel_o (blk_sel_o)
    );

endmodule

// File: tb/eeprom_addr_decoder_tb.sv
module eeprom_addr_decoder_tb;

    localparam int BLK = 1;
    localparam int Q   = 20;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe, match, rw;
    logic [2:0] blk;
    logic       sda_line;

    int total = 0;
    int fails = 0;
    int settle = 0;
    int match_cnt = 0;
    bit run_checks = 0;
    bit done = 0;

    logic       exp_oe = 1'b0;
    logic       exp_rw = 1'b0;
    logic [2:0] exp_blk = 3'b000;
    bit         listening = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_addr_decoder #(.BLK_BITS(BLK)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .pin_addr_i (pins),
        .sda_oe_o   (sda_oe),
        .match_o    (match),
        .rw_o       (rw),
        .blk_sel_o  (blk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (match) match_cnt++;
        if (run_checks && !done) begin
            if (settle >= SETTLE) begin
                chk(sda_oe == exp_oe, "R2 ack drive", sda_oe, exp_oe);
                chk(rw == exp_rw, "R6/R10 rw", rw, exp_rw);
                chk(blk == exp_blk, "R5/R10 blk_sel", blk, exp_blk);
            end
            settle++;
        end
    end

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic set_scl(input logic v);
        scl_m = v; settle = 0;
    endtask

    task automatic set_sda(input logic v);
        sda_m = v; settle = 0;
    endtask

    function automatic bit model_hit(input logic [7:0] b);
        if (b[7:4] != 4'b1010) return 0;
        for (int i = 1; i <= 3; i++)
            if (i > BLK && b[i] != pins[i-1]) return 0;
        return 1;
    endfunction

    task automatic bus_start();
        set_sda(1'b1); wait_q();
        set_scl(1'b1); wait_q();
        set_sda(1'b0); wait_q();
        set_scl(1'b0); wait_q();
        listening = 1;
    endtask

    task automatic bus_stop();
        set_sda(1'b0); wait_q();
        set_scl(1'b1); wait_q();
        set_sda(1'b1); wait_q();
        listening = 0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            set_sda(b[i]); wait_q();
            set_scl(1'b1); wait_q();
            set_scl(1'b0);
            if (i != 8 - n) wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        bit exp;
        int m0;
        exp = listening && model_hit(b);
        listening = 0;
        m0 = match_cnt;
        send_bits(b, 8);
        exp_oe = exp;
        if (exp) begin
            exp_rw  = b[0];
            exp_blk = 3'(b[BLK:1]);
        end
        set_sda(1'b1); wait_q();
        set_scl(1'b1); wait_q();
        set_scl(1'b0); exp_oe = 1'b0; wait_q();
        chk((match_cnt - m0) == int'(exp), tag, match_cnt - m0, int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(match == 1'b0, "R1 match", match, 0);
        chk(rw == 1'b0, "R1 rw", rw, 0);
        chk(blk == 3'b000, "R1 blk_sel", blk, 0);
        run_checks = 1;
        wait_q();

        // R2 R6 R7: read, block 1
        bus_start(); send_byte(8'b1010_10_1_1, "R7 match read blk1"); bus_stop();
        // R5: block bit opposite to pin A0 still matches; write
        bus_start(); send_byte(8'b1010_10_0_0, "R5 block bit uncompared"); bus_stop();
        // R3: wrong identifier
        bus_start(); send_byte(8'b1011_10_1_1, "R3 id mismatch"); bus_stop();
        bus_start(); send_byte(8'b0010_10_1_1, "R3 id mismatch msb"); bus_stop();
        // R4: pin-compared bits wrong
        bus_start(); send_byte(8'b1010_00_1_1, "R4 bit3 mismatch"); bus_stop();
        bus_start(); send_byte(8'b1010_11_1_1, "R4 bit2 mismatch"); bus_stop();
        // R8: mismatch then valid byte with no new start
        bus_start(); send_byte(8'b1110_10_1_1, "R8 first reject");
        send_byte(8'b1010_10_1_1, "R8 ignored after reject"); bus_stop();
        // R8: matched, then another byte without start gets no address ack
        bus_start(); send_byte(8'b1010_10_1_0, "R8 match before follow-on");
        send_byte(8'b1010_10_1_1, "R8 follow-on ignored"); bus_stop();
        // R9: start mid-byte restarts capture
        bus_start(); send_bits(8'b0101_0000, 3); wait_q();
        bus_start(); send_byte(8'b1010_10_0_1, "R9 restart mid-byte"); bus_stop();
        // R9: stop mid-byte abandons; next byte without start ignored
        bus_start(); send_bits(8'b1010_1000, 3); wait_q();
        bus_stop(); send_byte(8'b1010_10_1_1, "R9 stop mid-byte"); bus_stop();
        // R10: final match then values hold through idle
        bus_start(); send_byte(8'b1010_10_1_1, "R10 last match"); bus_stop();
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(rw == 1'b1, "R10 rw hold", rw, 1);
        chk(blk == 3'b001, "R10 blk hold", blk, 1);
        summary();
    end

endmodule